// File: doc/BRIEF.md
# Serial Nibble Command Target Behind a Software-Toggled Port

This block is a target device that a processor drives by toggling bits in an 8-bit port register. It does not use a hardware serial engine. One bit of the port is a clock line and has its own direction bit. Another bit is a data line and also has its own direction bit. The block watches every port write and recognises clock pulses from the written values. While the data line points outward from the host, each pulse delivers one command bit, most significant bit first. Every eight bits form a command byte.

A command byte holds four fields:
- Bit 7 must be 1.
- Bit 6 chooses between a read and a write.
- Bits 5:4 choose between an address transfer and a data transfer.
- Bits 3:0 carry a 4-bit payload.

An address transfer loads the current pointer into a 16-entry byte register file. A write data transfer stores the payload, zero-extended, at the current pointer. A read fetches the byte at the pointer. Its most significant bit appears on the data bit of the port at once. The host then turns the data line around and pulses the clock, collecting one more bit per pulse.

Host software integrates the block by writing and reading the port register only. The register file is internal, so the only way to observe its contents is the serial read command.

Top module: `nibble_cmd_slave`

## Requirements
- R1: A port write is a clock pulse only when the previously written value has bit 1 (clock direction) set and bit 0 (clock line) clear, and the new value has bit 0 set. No other write, including one that sets direction and line together, or one that keeps the line high, moves any protocol state.
- R2: On a pulse whose new value has bit 3 (data direction) set, bit 2 (data line) is shifted into the command byte from the low end. The first bit becomes bit 7. After the eighth such bit, the byte is decoded and the bit count restarts at zero.
- R3: A valid command with bits 5:4 = 10 loads the current address from bits 3:0. A write of this kind (bit 6 = 0) does nothing else.
- R4: A valid command with bit 6 = 0 and bits 5:4 = 01 stores {4'b0000, bits 3:0} at the current address.
- R5: A valid command with bit 6 = 1 fetches the byte at the current address. That address is the one just loaded if bits 5:4 = 10. The fetch drives the byte's bit 7 onto port bit 2 in the same write and resets the read index to 0.
- R6: On a pulse whose new value has bit 3 clear, the read index advances modulo 8 and port bit 2 shows bit (7 - index) of the fetched byte. The eighth pulse after a fetch therefore shows bit 7 again.
- R7: A decoded byte with bit 7 clear, or with bits 5:4 equal to 00 or 11, changes neither the address nor the register file, and sets cmdError. cmdError stays set until reset.
- R8: portRdData returns the last written value. Bit 2 is replaced by the target's bit only when that write caused a fetch or an input-mode pulse. Between writes, portRdData does not change.
- R9: After reset, portRdData is 0, cmdError is 0, the current address is 0 and every register-file entry is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portWrEn | input | 1 | One-cycle strobe: the host writes the port register |
| portWrData | input | 8 | Value written to the port register |
| portRdData | output | 8 | Port register as the host reads it back |
| cmdError | output | 1 | Sticky flag: a malformed command byte was received |

## Verification
The bound checker enforces several rules on every cycle:
- A read step is only ever taken on a genuine rising clock write while the data line is turned inward.
- At most one command action fires per write, and a malformed byte never triggers any action.
- The error flag never drops.
- The readback equals the written value after any write that drives nothing, and holds steady while no write occurs.

Only the bench scenarios can show the serial behaviour. These scenarios cover bit ordering, pointer and register-file contents, zero extension of nibbles, and the modulo-8 wrap of the read index. They also confirm that misaligned or spurious clock writes do not corrupt later commands. The bench compares every returned byte against its own model of the register file.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int ADDR_W = NIB_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CNT_W  = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    KIND_BAD  = 2'd0,
    KIND_ADDR = 2'd1,
    KIND_DATA = 2'd2
  } cmdKind_e;

  // Strobes from the control side into the datapath, valid for one cycle.
  typedef struct packed {
    logic             loadAddr;
    logic             writeNib;
    logic             fetch;
    logic             advance;
    logic             setErr;
    logic [NIB_W-1:0] payload;
  } nbcStrobe_t;

endpackage

// File: rtl/nbc_ctrl.sv
module nbc_ctrl
  import nbc_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int CLK_BIT     = 0,
  parameter int CLK_DIR_BIT = 1,
  parameter int DAT_BIT     = 2,
  parameter int DAT_DIR_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portWrEn,
  input  logic [PORT_W-1:0] portWrData,
  input  logic [PORT_W-1:0] prevPort,
  output nbcStrobe_t        stb
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              pulse;
  logic              shiftIn;
  logic              readStep;
  logic              cmdDone;
  logic [BYTE_W-1:0] nextCmd;
  logic              isRead;
  cmdKind_e          kind;

  // Edge on the clock line, qualified by the direction bit of the prior value.
  assign pulse    = portWrEn && prevPort[CLK_DIR_BIT] && !prevPort[CLK_BIT]
                    && portWrData[CLK_BIT];
  assign shiftIn  = pulse && portWrData[DAT_DIR_BIT];
  assign readStep = pulse && !portWrData[DAT_DIR_BIT];
  assign nextCmd  = {shiftReg[BYTE_W-2:0], portWrData[DAT_BIT]};
  assign cmdDone  = shiftIn && (bitCnt == LAST_BIT);
  assign isRead   = nextCmd[6];

  always_comb begin
    kind = KIND_BAD;
    if (nextCmd[7]) begin
      case (nextCmd[5:4])
        2'b10:   kind = KIND_ADDR;
        2'b01:   kind = KIND_DATA;
        default: kind = KIND_BAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (shiftIn) begin
      shiftReg <= nextCmd;
      bitCnt   <= cmdDone ? '0 : bitCnt + 1'b1;
    end
  end

  always_comb begin
    stb          = '0;
    stb.payload  = nextCmd[NIB_W-1:0];
    stb.advance  = readStep;
    if (cmdDone) begin
      stb.setErr   = (kind == KIND_BAD);
      stb.loadAddr = (kind == KIND_ADDR);
      stb.writeNib = (kind == KIND_DATA) && !isRead;
      stb.fetch    = (kind != KIND_BAD) && isRead;
    end
  end

endmodule

// File: rtl/nbc_datapath.sv
module nbc_datapath
  import nbc_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int DAT_BIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portWrEn,
  input  logic [PORT_W-1:0] portWrData,
  input  nbcStrobe_t        stb,
  output logic [PORT_W-1:0] portReg,
  output logic [PORT_W-1:0] portRdData,
  output logic              errFlag
);

  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] regFile [DEPTH];
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] fetchAddr;
  logic [BYTE_W-1:0] readByte;
  logic [CNT_W-1:0]  rdIdx;
  logic [CNT_W-1:0]  nextIdx;
  logic              driveBit;
  logic              driveValid;

  assign fetchAddr = stb.loadAddr ? stb.payload : curAddr;
  assign nextIdx   = rdIdx + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portReg    <= '0;
      curAddr    <= '0;
      readByte   <= '0;
      rdIdx      <= '0;
      driveBit   <= 1'b0;
      driveValid <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      if (portWrEn) portReg <= portWrData;
      if (stb.loadAddr) curAddr <= stb.payload;
      if (stb.setErr) errFlag <= 1'b1;
      if (stb.fetch) begin
        readByte   <= regFile[fetchAddr];
        rdIdx      <= '0;
        driveBit   <= regFile[fetchAddr][BYTE_W-1];
        driveValid <= 1'b1;
      end else if (stb.advance) begin
        rdIdx      <= nextIdx;
        driveBit   <= readByte[TOP_IDX - nextIdx];
        driveValid <= 1'b1;
      end else if (portWrEn) begin
        driveValid <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN)
        regFile[g] <= '0;
      else if (stb.writeNib && (curAddr == ADDR_W'(g)))
        regFile[g] <= {{(BYTE_W-NIB_W){1'b0}}, stb.payload};
    end
  end

  always_comb begin
    portRdData = portReg;
    if (driveValid) portRdData[DAT_BIT] = driveBit;
  end

endmodule

// File: rtl/nibble_cmd_slave.sv
module nibble_cmd_slave
  import nbc_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int CLK_BIT     = 0,
  parameter int CLK_DIR_BIT = 1,
  parameter int DAT_BIT     = 2,
  parameter int DAT_DIR_BIT = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portWrEn,
  input  logic [PORT_W-1:0] portWrData,
  output logic [PORT_W-1:0] portRdData,
  output logic              cmdError
);

  nbcStrobe_t        stb;
  logic [PORT_W-1:0] portReg;

  nbc_ctrl #(
    .PORT_W(PORT_W), .CLK_BIT(CLK_BIT), .CLK_DIR_BIT(CLK_DIR_BIT),
    .DAT_BIT(DAT_BIT), .DAT_DIR_BIT(DAT_DIR_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .portWrEn(portWrEn), .portWrData(portWrData),
    .prevPort(portReg), .stb(stb)
  );

  nbc_datapath #(
    .PORT_W(PORT_W), .DAT_BIT(DAT_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .portWrEn(portWrEn), .portWrData(portWrData),
    .stb(stb), .portReg(portReg), .portRdData(portRdData), .errFlag(cmdError)
  );

endmodule

// File: rtl/nbc_checker.sv
module nbc_checker
  import nbc_pkg::*;
#(
  parameter int PORT_W      = 8,
  parameter int CLK_BIT     = 0,
  parameter int CLK_DIR_BIT = 1,
  parameter int DAT_DIR_BIT = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              portWrEn,
  input logic [PORT_W-1:0] portWrData,
  input logic [PORT_W-1:0] prevPort,
  input logic [PORT_W-1:0] portRdData,
  input logic              errFlag,
  input nbcStrobe_t        stb
);

  assert_step_on_edge_R1: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance |-> (portWrEn && prevPort[CLK_DIR_BIT] && !prevPort[CLK_BIT]
                     && portWrData[CLK_BIT] && !portWrData[DAT_DIR_BIT]));

  assert_single_action_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.fetch, stb.advance, stb.writeNib, stb.setErr}));

  assert_bad_cmd_inert_R7: assert property (@(posedge clk) disable iff (!rstN)
    stb.setErr |-> !(stb.loadAddr || stb.writeNib || stb.fetch));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  assert_plain_readback_R8: assert property (@(posedge clk) disable iff (!rstN)
    (portWrEn && !stb.fetch && !stb.advance) |=> portRdData == $past(portWrData));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    !portWrEn |=> $stable(portRdData));

endmodule

bind nibble_cmd_slave nbc_checker #(
  .PORT_W(PORT_W), .CLK_BIT(CLK_BIT), .CLK_DIR_BIT(CLK_DIR_BIT),
  .DAT_DIR_BIT(DAT_DIR_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .portWrEn(portWrEn), .portWrData(portWrData),
  .prevPort(portReg), .portRdData(portRdData), .errFlag(cmdError), .stb(stb)
);

// File: tb/tb_nibble_cmd_slave.sv
module tb_nibble_cmd_slave;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portWrEn = 1'b0;
  logic [7:0] portWrData = '0;
  logic [7:0] portRdData;
  logic       cmdError;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] mdl [16];
  logic [3:0] mAddr;

  always #2 clk = ~clk;

  nibble_cmd_slave dut (
    .clk(clk), .rstN(rstN), .portWrEn(portWrEn), .portWrData(portWrData),
    .portRdData(portRdData), .cmdError(cmdError)
  );

  function automatic logic [7:0] pv(input logic c, input logic cd,
                                    input logic d, input logic dd);
    logic [7:0] v;
    v = '0;
    v[0] = c; v[1] = cd; v[2] = d; v[3] = dd;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    portWrEn = 1'b1;
    portWrData = v;
    @(negedge clk);
    portWrEn = 1'b0;
  endtask

  task automatic sendBit(input logic b);
    wr(pv(1'b0, 1'b1, b, 1'b1));
    wr(pv(1'b1, 1'b1, b, 1'b1));
  endtask

  task automatic sendCmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) sendBit(c[i]);
  endtask

  task automatic stepIn(output logic b);
    wr(pv(1'b0, 1'b1, 1'b0, 1'b0));
    wr(pv(1'b1, 1'b1, 1'b0, 1'b0));
    b = portRdData[2];
  endtask

  task automatic getByte(output logic [7:0] b);
    logic x;
    b[7] = portRdData[2];
    for (int i = 6; i >= 0; i--) begin
      stepIn(x);
      b[i] = x;
    end
  endtask

  task automatic opAddr(input logic [3:0] a);
    sendCmd({4'hA, a});
    mAddr = a;
  endtask

  task automatic opData(input logic [3:0] d);
    sendCmd({4'h9, d});
    mdl[mAddr] = {4'h0, d};
  endtask

  task automatic opReadAddr(input logic [3:0] a, input string tag);
    logic [7:0] b;
    sendCmd({4'hE, a});
    mAddr = a;
    getByte(b);
    chk(b == mdl[a], tag, b, mdl[a]);
  endtask

  task automatic opReadCur(input logic [3:0] junk, input string tag);
    logic [7:0] b;
    sendCmd({4'hD, junk});
    getByte(b);
    chk(b == mdl[mAddr], tag, b, mdl[mAddr]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic x;
    int seed;
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    mAddr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk(portRdData == 8'h00, "R9 port after reset", portRdData, 0);
    chk(cmdError == 1'b0, "R9 error after reset", cmdError, 0);
    opReadCur(4'h7, "R9 entry at address zero");
    opReadAddr(4'hF, "R9 last entry zero");

    // R3 R4 address load and nibble store, zero extended
    opAddr(4'h5);
    opData(4'hC);
    opReadAddr(4'h5, "R4 stored nibble");
    opAddr(4'h5);
    opData(4'hF);
    opAddr(4'h2);
    opReadAddr(4'h5, "R3 address load then read");

    // R8 plain readback, then replacement after a fetch
    wr(pv(1'b0, 1'b1, 1'b1, 1'b1));
    chk(portRdData == pv(1'b0, 1'b1, 1'b1, 1'b1), "R8 plain readback",
        portRdData, pv(1'b0, 1'b1, 1'b1, 1'b1));
    sendCmd(8'hE5);
    chk(portRdData == pv(1'b1, 1'b1, 1'b0, 1'b1), "R8 R5 MSB replaces data bit",
        portRdData, pv(1'b1, 1'b1, 1'b0, 1'b1));
    getByte(b);
    chk(b == 8'h0F, "R5 fetched byte", b, 8'h0F);

    // R6 modulo-8 wrap: eight more steps repeat the byte
    for (int i = 7; i >= 0; i--) begin
      stepIn(x);
      chk(x == b[i], "R6 wrapped bit", x, b[i]);
    end

    // R1 spurious clock writes: direction and line set together, line held high
    wr(pv(1'b0, 1'b0, 1'b0, 1'b0));
    wr(pv(1'b1, 1'b1, 1'b1, 1'b1));
    wr(pv(1'b1, 1'b1, 1'b1, 1'b1));
    opAddr(4'h9);
    opData(4'h6);
    opReadAddr(4'h9, "R1 no spurious pulse");
    wr(pv(1'b1, 1'b0, 1'b0, 1'b1));
    wr(pv(1'b0, 1'b0, 1'b0, 1'b1));
    wr(pv(1'b1, 1'b0, 1'b1, 1'b1));
    opReadCur(4'h0, "R1 clock direction clear ignored");

    // R7 malformed commands
    chk(cmdError == 1'b0, "R7 error clear before bad command", cmdError, 0);
    opAddr(4'h3);
    opData(4'h4);
    sendCmd(8'h15);
    chk(cmdError == 1'b1, "R7 bit7 clear sets error", cmdError, 1);
    opReadCur(4'h0, "R7 bit7 clear does not write");
    sendCmd(8'hB8);
    sendCmd(8'h87);
    opReadCur(4'h0, "R7 fields 11 and 00 leave address");
    chk(cmdError == 1'b1, "R7 error sticky", cmdError, 1);

    // R2 R3 R4 R5 random mix
    seed = 32'h5EED1;
    void'($urandom(seed));
    for (int n = 0; n < 150; n++) begin
      case ($urandom_range(0, 3))
        0: opAddr(4'($urandom_range(0, 15)));
        1: opData(4'($urandom_range(0, 15)));
        2: opReadAddr(4'($urandom_range(0, 15)), "R5 random read by address");
        default: opReadCur(4'($urandom_range(0, 15)), "R2 random read current");
      endcase
    end

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule